// File: doc/BRIEF.md
# Clear-on-read interrupt status unit

This block gathers per-channel event pulses produced by a periodic round-robin monitoring sequencer and turns them into a sticky interrupt status register with a hardware interrupt line. Events caught during a monitoring pass are staged internally. They are published into the status register only when the sequencer signals that the pass is complete. Because of this, software sees a coherent snapshot of one whole pass.

The host reaches the block through a simple register port. The port has a one-cycle read strobe, a write strobe and an address. A read of the status register returns its contents and zeroes it in the same access. The status then stays at zero, and the interrupt line stays released, until the next completed pass publishes new events. Every access is accepted in the cycle it is presented. There is no back-pressure, and read data appears registered one cycle later.

A configuration register holds two bits. One is a global enable for the interrupt line. The other is a clear bit that forces the line inactive and holds the monitoring sequencer stopped for as long as it is set. Each source also has its own mask bit. The interrupt output is active low and open-drain. It is modelled as an output-enable with a constant-zero data value.

Top module: `irq_status_unit`

## Requirements
- R1: A read strobe at address 0 returns the status register on `reg_rdata_o` in the cycle after the strobe, and the status register is zero after that same edge.
- R2: Status bits become set only at an edge where `pass_done_i` is high. Events seen between passes are held back, so a read made before the next pass completes returns 0.
- R3: After a read clears the status, `int_oe_o` stays 0 until a completed pass publishes at least one unmasked bit.
- R4: With mask bit i equal to 1 (mask register at address 1, bit i for source i), events on source i are discarded and never set status bit i. A status bit that is already set does not drive the output while its mask bit is 1.
- R5: When configuration bit 0 (global enable) is 0, `int_oe_o` is 0. When it is 1, and bit 3 is 0, `int_oe_o` is 1 exactly when some status bit is set and unmasked.
- R6: While configuration bit 3 (interrupt clear) is 1, `int_oe_o` is 0 and `seq_hold_o` is 1. Clearing the bit releases the hold and restores the output if unmasked status bits remain.
- R7: If a status read and `pass_done_i` fall in the same cycle, the read returns the old status and the status register keeps the newly published bits. An event that arrives in the pass-complete cycle is part of that publication.
- R8: Address 1 (mask) and address 2 (configuration, bits 0 and 3, other bits read 0) are read/write. Writes to address 0 are ignored, and reads of any other address return 0.
- R9: Status bits are sticky. Bits published by successive passes accumulate until a read clears them.
- R10: After reset the status, staged events, mask, configuration and read data are all zero, and `int_oe_o` and `seq_hold_o` are 0. `int_do_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_SRC | Per-channel event pulses from the monitoring sequencer |
| pass_done_i | input | 1 | Strobe marking the end of a full monitoring pass |
| seq_hold_o | output | 1 | Holds the monitoring sequencer stopped while high |
| reg_rd_i | input | 1 | One-cycle register read strobe |
| reg_wr_i | input | 1 | One-cycle register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| int_oe_o | output | 1 | Interrupt pin output-enable (1 pulls the line low) |
| int_do_o | output | 1 | Interrupt pin data value, constant 0 |

## Verification
The hardest situation to reach is a status read that lands in the very cycle a pass completes, especially when a fresh event arrives in that same cycle. If the ordering is wrong there, an interrupt is silently lost. The bench aims a directed sequence at that exact cycle. On top of that, random traffic drives reads and pass-complete strobes with high enough probability that they coincide many times, and a bench model checks every read value and the interrupt line on every cycle.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_MASK   = 1;
  localparam int unsigned ADDR_CFG    = 2;
  localparam int unsigned CFG_EN_BIT  = 0;
  localparam int unsigned CFG_CLR_BIT = 3;

  typedef struct packed {
    logic clr;
    logic en;
  } cfg_t;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               pass_done_i,
  input  logic               rd_clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] pend_q, pend_nxt, status_q, status_kept;

  // masked sources are dropped at the door (R4)
  assign pend_nxt    = pend_q | (evt_i & ~mask_i);
  assign status_kept = rd_clr_i ? '0 : status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      status_q <= '0;
    end else if (pass_done_i) begin
      // publication wins over a same-cycle read (R7), accumulates (R9)
      status_q <= status_kept | pend_nxt;
      pend_q   <= '0;
    end else begin
      status_q <= status_kept;
      pend_q   <= pend_nxt;
    end
  end

  assign status_o = status_q;

  a_r1_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !pass_done_i) |=> (status_o == '0));

  a_r2_only_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_done_i |=> ((status_o & ~$past(status_o)) == '0));

  a_r4_masked_never_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_done_i && (pend_q & mask_i) == '0 && (status_o & mask_i) == '0)
      |=> ((status_o & ~$past(status_o) & $past(mask_i)) == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_stat_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [NUM_SRC-1:0] mask_o,
  output cfg_t               cfg_o,
  output logic               rd_clr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [NUM_SRC-1:0] mask_q;
  cfg_t               cfg_q;
  logic [DATA_W-1:0]  rdata_q, rdata_nxt;
  logic               hit_status, hit_mask, hit_cfg;

  assign hit_status = (addr_i == ADDR_W'(ADDR_STATUS));
  assign hit_mask   = (addr_i == ADDR_W'(ADDR_MASK));
  assign hit_cfg    = (addr_i == ADDR_W'(ADDR_CFG));
  assign rd_clr_o   = rd_i && hit_status;

  always_comb begin
    rdata_nxt = '0;
    if (hit_status) begin
      rdata_nxt[NUM_SRC-1:0] = status_i;
    end else if (hit_mask) begin
      rdata_nxt[NUM_SRC-1:0] = mask_q;
    end else if (hit_cfg) begin
      rdata_nxt[CFG_EN_BIT]  = cfg_q.en;
      rdata_nxt[CFG_CLR_BIT] = cfg_q.clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      cfg_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_i && hit_mask) mask_q <= wdata_i[NUM_SRC-1:0];
      if (wr_i && hit_cfg) begin
        cfg_q.en  <= wdata_i[CFG_EN_BIT];
        cfg_q.clr <= wdata_i[CFG_CLR_BIT];
      end
      if (rd_i) rdata_q <= rdata_nxt;
    end
  end

  assign mask_o  = mask_q;
  assign cfg_o   = cfg_q;
  assign rdata_o = rdata_q;

  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));

  a_r8_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(cfg_o) && $stable(mask_o));
endmodule

// File: rtl/irq_out.sv
module irq_out
  import irq_stat_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  cfg_t               cfg_i,
  output logic               int_oe_o,
  output logic               seq_hold_o
);
  logic live;

  assign live       = |(status_i & ~mask_i);
  assign int_oe_o   = cfg_i.en && !cfg_i.clr && live;
  assign seq_hold_o = cfg_i.clr;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               pass_done_i,
  output logic               seq_hold_o,
  input  logic               reg_rd_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               int_oe_o,
  output logic               int_do_o
);
  logic [NUM_SRC-1:0] status, mask;
  cfg_t               cfg;
  logic               rd_clr;

  irq_capture #(.NUM_SRC(NUM_SRC)) cap_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mask_i(mask),
    .pass_done_i(pass_done_i), .rd_clr_i(rd_clr), .status_o(status)
  );

  irq_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .rd_i(reg_rd_i), .wr_i(reg_wr_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .status_i(status),
    .mask_o(mask), .cfg_o(cfg), .rd_clr_o(rd_clr), .rdata_o(reg_rdata_o)
  );

  irq_out #(.NUM_SRC(NUM_SRC)) out_i (
    .status_i(status), .mask_i(mask), .cfg_i(cfg),
    .int_oe_o(int_oe_o), .seq_hold_o(seq_hold_o)
  );

  assign int_do_o = 1'b0;

  a_r6_clr_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.clr |-> !int_oe_o);

  a_r3_low_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !pass_done_i) |=> !int_oe_o);

  a_r5_disabled_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> !int_oe_o);

  a_r6_hold_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_i |=> $stable(seq_hold_o));

  a_r10_pin_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    int_do_o == 1'b0);
endmodule

// File: tb/irq_status_unit_tb_top.sv
module irq_status_unit_tb_top;
  localparam int N  = 8;
  localparam int DW = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt = '0;
  logic          pd = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          seq_hold, int_oe, int_do;

  int total = 0;
  int bad   = 0;

  // bench model
  logic [N-1:0] m_pend = '0, m_stat = '0, m_mask = '0;
  logic         m_en = 1'b0, m_clr = 1'b0;

  always #5 clk = ~clk;

  irq_status_unit #(.NUM_SRC(N), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .pass_done_i(pd),
    .seq_hold_o(seq_hold), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .int_oe_o(int_oe), .int_do_o(int_do)
  );

  function automatic logic exp_oe();
    return m_en && !m_clr && ((m_stat & ~m_mask) != '0);
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    case (a)
      3'd0: v[N-1:0] = m_stat;
      3'd1: v[N-1:0] = m_mask;
      3'd2: begin v[0] = m_en; v[3] = m_clr; end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic [N-1:0] e, input logic p, input logic r,
                       input logic w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string tag);
    logic [DW-1:0] exp_rd;
    logic [N-1:0]  pn, keep;
    @(negedge clk);
    evt = e; pd = p; rd = r; wr = w; addr = a; wdata = d;
    exp_rd = exp_read(a);
    pn     = m_pend | (e & ~m_mask);
    keep   = (r && a == 3'd0) ? '0 : m_stat;
    if (p) begin m_stat = keep | pn; m_pend = '0; end
    else begin m_stat = keep; m_pend = pn; end
    if (w && a == 3'd1) m_mask = d[N-1:0];
    if (w && a == 3'd2) begin m_en = d[0]; m_clr = d[3]; end
    @(posedge clk);
    #1;
    if (r) check({tag, " rdata"}, 32'(rdata), 32'(exp_rd));
    check({tag, " int_oe"}, 32'(int_oe), 32'(exp_oe()));
    check({tag, " seq_hold"}, 32'(seq_hold), 32'(m_clr));
    check("R10 int_do", 32'(int_do), 32'd0);
    evt = '0; pd = 0; rd = 0; wr = 0;
  endtask

  initial begin : watchdog
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset oe", 32'(int_oe), 32'd0);
    check("R10 reset hold", 32'(seq_hold), 32'd0);
    check("R10 reset rdata", 32'(rdata), 32'd0);
    rst_n = 1'b1;
    cycle('0, 0, 1, 0, 3'd1, '0, "R10 mask reset");
    cycle('0, 0, 1, 0, 3'd2, '0, "R10 cfg reset");

    // R2 / R1 / R3 basic flow
    cycle('0, 0, 0, 1, 3'd2, 8'h01, "R5 enable");
    cycle(8'h04, 0, 0, 0, 3'd0, '0, "R2 event staged");
    cycle('0, 0, 1, 0, 3'd0, '0, "R2 read before pass");
    cycle('0, 1, 0, 0, 3'd0, '0, "R3 pass publishes");
    cycle('0, 0, 1, 0, 3'd0, '0, "R1 read returns status");
    cycle('0, 0, 1, 0, 3'd0, '0, "R2 second read zero");
    cycle('0, 0, 0, 0, 3'd0, '0, "R3 stays low");

    // R9 sticky accumulation
    cycle(8'h01, 1, 0, 0, 3'd0, '0, "R9 pass one");
    cycle(8'h80, 1, 0, 0, 3'd0, '0, "R9 pass two");
    cycle('0, 0, 1, 0, 3'd0, '0, "R9 accumulated read");

    // R4 masking
    cycle('0, 0, 0, 1, 3'd1, 8'h02, "R4 mask bit1");
    cycle(8'h03, 1, 0, 0, 3'd0, '0, "R4 masked event");
    cycle('0, 0, 1, 0, 3'd0, '0, "R4 masked read");
    cycle(8'h10, 1, 0, 0, 3'd0, '0, "R4 set bit4");
    cycle('0, 0, 0, 1, 3'd1, 8'h12, "R4 mask existing bit");
    cycle('0, 0, 0, 1, 3'd1, 8'h00, "R4 unmask");

    // R6 clear bit and hold
    cycle('0, 0, 0, 1, 3'd2, 8'h09, "R6 clr set");
    cycle(8'h20, 0, 0, 0, 3'd0, '0, "R6 held");
    cycle('0, 0, 1, 0, 3'd2, '0, "R8 cfg readback");
    cycle('0, 0, 0, 1, 3'd2, 8'h01, "R6 clr release");

    // R5 global disable
    cycle('0, 0, 0, 1, 3'd2, 8'h00, "R5 disable");
    cycle('0, 1, 0, 0, 3'd0, '0, "R5 pass while off");
    cycle('0, 0, 0, 1, 3'd2, 8'h01, "R5 re-enable");

    // R7 read coinciding with pass and event
    cycle(8'h08, 0, 0, 0, 3'd0, '0, "R7 stage");
    cycle(8'h40, 1, 1, 0, 3'd0, '0, "R7 read at pass");
    cycle('0, 0, 1, 0, 3'd0, '0, "R7 kept bits");

    // R8 map
    cycle('0, 1, 0, 1, 3'd0, 8'hFF, "R8 status write ignored");
    cycle('0, 0, 1, 0, 3'd0, '0, "R8 status after write");
    cycle('0, 0, 1, 0, 3'd5, '0, "R8 unmapped read");
    cycle('0, 0, 0, 1, 3'd1, 8'hA5, "R8 mask write");
    cycle('0, 0, 1, 0, 3'd1, '0, "R8 mask readback");
    cycle('0, 0, 0, 1, 3'd1, 8'h00, "R8 mask clear");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0]  e;
      logic          p, r, w;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      e = N'($urandom) & N'($urandom) & N'($urandom);
      p = ($urandom % 4) == 0;
      r = ($urandom % 3) == 0;
      w = !r && (($urandom % 10) == 0);
      a = AW'($urandom % 4);
      d = DW'($urandom);
      if (w && a == 3'd2 && ($urandom % 2) == 0) d[3] = 1'b0;
      cycle(e, p, r, w, a, d, "R7 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule